// File: doc/BRIEF.md
# Gated PWM Power-Switch Driver

This block produces two independent pulse-width-modulated drive signals, each meant to switch the power transistor of an external switching regulator. Software stores two period/high-time settings per channel through a small APB slave with 8-bit data. A configuration-select pin on each channel chooses which of its two settings is in use. A live feedback pin from the analog loop gates each output: while feedback is low, the output sits at its inactive level. The active level of each output is set by a strap pin that is sampled while the reference-clock reset is held. One shared enable drives the bidirectional output pads.

The PWM counters run on a free-running reference clock that has no fixed relation to the bus clock. Register contents reach that domain as one snapshot through a toggle request/acknowledge handshake with two-flop synchronizers. Feedback and select pins also pass through two flops before use. Period and high-time are only reloaded at a period boundary, so a pin change or a register change never truncates a pulse.

Top module: `pwm_switch_driver`

## Requirements
- R1: Eight byte registers sit at word offsets 0 to 7 (paddr[7:2]). The byte at offset k = 4*channel + 2*setting + field holds the period (field 0) or the high-time (field 1). Each byte reads back what was written. Offsets 8 and up read as zero. The two channels run independently.
- R2: Each channel's strap pin is sampled while the reference reset is held. Strap 0 gives an active-high output and strap 1 gives an active-low output. The inactive level is driven during reset.
- R3: While a channel's feedback pin is low, that output stays at its inactive level.
- R4: A channel's select pin picks setting 0 when low and setting 1 when high.
- R5: A period lasts period+1 reference cycles. The output is active for the first high-time cycles of it. A high-time of 0 keeps the output inactive, and a high-time above the period keeps it active.
- R6: A new setting, whether from the select pin or from a register, takes effect only at the next period boundary. The period that is running finishes with its old high-time and length.
- R7: Register writes reach the PWM counters as one whole snapshot. After the handshake and at most one old period, the counters use the new values.
- R8: The pad output enable is low during reset and goes high on the first reference clock edge after the reset is released.
- R9: A register is written only in a cycle where psel, penable and pwrite are all high. A setup cycle with penable low leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Bus reset, active low |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 6 | Word address, bits [7:2] |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data |
| ref_clk | input | 1 | Free-running PWM reference clock |
| ref_rst_n | input | 1 | Reference-domain reset, active low, released synchronously |
| pol_strap | input | 2 | Per-channel polarity strap |
| fb_in | input | 2 | Per-channel analog feedback gate |
| cfg_sel | input | 2 | Per-channel setting select |
| drive_out | output | 2 | Per-channel PWM drive |
| drive_oe | output | 1 | Shared pad output enable |

## Verification
If the period counter or its loaded period/high-time registers hold a wrong value, a pulse width or a period length at drive_out is wrong. This shows within one period of at most 256 reference cycles. The bench therefore locks onto an observed rising of the active level and compares every following reference cycle with a behavioural waveform. A boundary-reload fault shows up as a pulse whose width or spacing belongs to neither setting, just after a select change. A polarity-latch or gating fault shows as an inverted or ungated level on the very next sampled cycle.

// File: rtl/pwm_drv_pkg.sv
package pwm_drv_pkg;
  parameter int unsigned VAL_W = 8;
  localparam int unsigned BYTES_PER_CH = 4;

  // Register slot of a value: channel, setting, field (0 period, 1 high-time)
  function automatic int unsigned slot_of(int unsigned ch, int unsigned setting,
                                          int unsigned field);
    return ch * BYTES_PER_CH + setting * 2 + field;
  endfunction

  // Active phase: counter position below the high-time
  function automatic logic in_high_phase(logic [VAL_W-1:0] cnt, logic [VAL_W-1:0] hi);
    return cnt < hi;
  endfunction
endpackage

// File: rtl/sync2.sv
module sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/apb_cfg_regs.sv
module apb_cfg_regs
  import pwm_drv_pkg::*;
#(
  parameter int unsigned NREG = 8
) (
  input  logic                  pclk,
  input  logic                  presetn,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pwrite,
  input  logic [7:2]            paddr,
  input  logic [VAL_W-1:0]      pwdata,
  output logic [VAL_W-1:0]      prdata,
  input  logic                  ack_t,
  output logic                  req_t,
  output logic [NREG*VAL_W-1:0] snap
);
  localparam int unsigned IDX_W = $clog2(NREG);

  logic [VAL_W-1:0]      regs [NREG];
  logic [NREG*VAL_W-1:0] regs_flat;
  logic                  ack_s, dirty, busy, hit, wr_hit;
  logic [IDX_W-1:0]      idx;

  sync2 #(.W(1)) u_ack_sync (.clk(pclk), .rst_n(presetn), .d(ack_t), .q(ack_s));

  assign hit    = 32'(paddr) < NREG;
  assign idx    = paddr[IDX_W+1:2];
  assign wr_hit = psel && penable && pwrite && hit;
  assign busy   = req_t != ack_s;
  assign prdata = (psel && !pwrite && hit) ? regs[idx] : '0;

  always_comb begin
    for (int i = 0; i < NREG; i++) regs_flat[i*VAL_W +: VAL_W] = regs[i];
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      dirty <= 1'b0;
      req_t <= 1'b0;
      snap  <= '0;
    end else begin
      if (dirty && !busy) begin
        snap  <= regs_flat;
        req_t <= ~req_t;
        dirty <= 1'b0;
      end
      if (wr_hit) begin
        regs[idx] <= pwdata;
        dirty     <= 1'b1;
      end
    end
  end

  // R7: the snapshot stays still while the far side may be capturing it
  a_r7_snap_hold: assert property (@(posedge pclk) disable iff (!presetn)
    $past(busy) |-> $stable(snap));
  // R9: registers change only after a full access-phase write
  a_r9_write_needs_access: assert property (@(posedge pclk) disable iff (!presetn)
    !(psel && penable && pwrite) |=> $stable(regs_flat));
endmodule

// File: rtl/cfg_cdc_sink.sv
module cfg_cdc_sink
  import pwm_drv_pkg::*;
#(
  parameter int unsigned NREG = 8
) (
  input  logic                  ref_clk,
  input  logic                  ref_rst_n,
  input  logic                  req_t,
  input  logic [NREG*VAL_W-1:0] snap,
  output logic                  ack_t,
  output logic [NREG*VAL_W-1:0] cfg_bank
);
  logic req_s, req_q, take;

  sync2 #(.W(1)) u_req_sync (.clk(ref_clk), .rst_n(ref_rst_n), .d(req_t), .q(req_s));

  assign take = req_s ^ req_q;

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      req_q    <= 1'b0;
      ack_t    <= 1'b0;
      cfg_bank <= '0;
    end else begin
      req_q <= req_s;
      if (take) begin
        cfg_bank <= snap;
        ack_t    <= req_s;
      end
    end
  end

  // R7: the bank changes only as a whole on a handshake capture
  a_r7_bank_atomic: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !$past(take) |-> $stable(cfg_bank));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_drv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VAL_W-1:0] per0,
  input  logic [VAL_W-1:0] hi0,
  input  logic [VAL_W-1:0] per1,
  input  logic [VAL_W-1:0] hi1,
  input  logic             sel_s,
  input  logic             fb_s,
  input  logic             pol,
  output logic             drive
);
  logic [VAL_W-1:0] cnt, per_q, hi_q;
  logic             boundary, active;

  assign boundary = cnt == per_q;
  assign active   = in_high_phase(cnt, hi_q) && fb_s;
  assign drive    = pol ^ active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      per_q <= '0;
      hi_q  <= '0;
    end else if (boundary) begin
      cnt   <= '0;
      per_q <= sel_s ? per1 : per0;
      hi_q  <= sel_s ? hi1 : hi0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5: counter never passes the loaded period
  a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_q);
  // R6: loaded values hold for the whole period
  a_r6_mid_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> ($stable(per_q) && $stable(hi_q)));
endmodule

// File: rtl/pwm_switch_driver.sv
module pwm_switch_driver
  import pwm_drv_pkg::*;
#(
  parameter int unsigned NCH = 2
) (
  input  logic             pclk,
  input  logic             presetn,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [7:2]       paddr,
  input  logic [VAL_W-1:0] pwdata,
  output logic [VAL_W-1:0] prdata,
  input  logic             ref_clk,
  input  logic             ref_rst_n,
  input  logic [NCH-1:0]   pol_strap,
  input  logic [NCH-1:0]   fb_in,
  input  logic [NCH-1:0]   cfg_sel,
  output logic [NCH-1:0]   drive_out,
  output logic             drive_oe
);
  localparam int unsigned NREG = NCH * BYTES_PER_CH;

  logic                  req_t, ack_t;
  logic [NREG*VAL_W-1:0] snap, cfg_bank;
  logic [NCH-1:0]        fb_s, sel_s, pol_q;
  logic                  oe_q;

  apb_cfg_regs #(.NREG(NREG)) u_regs (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .ack_t(ack_t), .req_t(req_t), .snap(snap)
  );

  cfg_cdc_sink #(.NREG(NREG)) u_sink (
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .req_t(req_t), .snap(snap),
    .ack_t(ack_t), .cfg_bank(cfg_bank)
  );

  sync2 #(.W(2*NCH)) u_pin_sync (
    .clk(ref_clk), .rst_n(ref_rst_n), .d({cfg_sel, fb_in}), .q({sel_s, fb_s})
  );

  // Enable rises on the first edge after release; strap follows the pins until then
  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) oe_q <= 1'b0;
    else            oe_q <= 1'b1;
  end

  always_ff @(posedge ref_clk) begin
    if (!oe_q) pol_q <= pol_strap;
  end

  assign drive_oe = oe_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_channel u_ch (
      .clk(ref_clk), .rst_n(ref_rst_n),
      .per0(cfg_bank[slot_of(c, 0, 0)*VAL_W +: VAL_W]),
      .hi0 (cfg_bank[slot_of(c, 0, 1)*VAL_W +: VAL_W]),
      .per1(cfg_bank[slot_of(c, 1, 0)*VAL_W +: VAL_W]),
      .hi1 (cfg_bank[slot_of(c, 1, 1)*VAL_W +: VAL_W]),
      .sel_s(sel_s[c]), .fb_s(fb_s[c]), .pol(pol_q[c]), .drive(drive_out[c])
    );

    // R3: low synchronized feedback forces the inactive level
    a_r3_fb_gate: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      !fb_s[c] |-> (drive_out[c] == pol_q[c]));
  end

  // R8: enable stays high once out of reset
  a_r8_oe_after_release: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $past(ref_rst_n) |-> drive_oe);
  // R2: polarity is frozen once the enable is up
  a_r2_pol_frozen: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $past(drive_oe) |-> $stable(pol_q));
endmodule

// File: tb/tb_pwm_switch_driver.sv
module tb_pwm_switch_driver;
  localparam int CLK_PERIOD = 10;
  localparam int REF_PERIOD = 14;
  localparam int WATCHDOG   = 150000;

  logic       pclk = 1'b0, ref_clk = 1'b0;
  logic       presetn = 1'b0, ref_rst_n = 1'b0;
  logic       psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:2] paddr = '0;
  logic [7:0] pwdata = '0;
  logic [7:0] prdata;
  logic [1:0] pol_strap = 2'b10, fb_in = 2'b00, cfg_sel = 2'b00;
  logic [1:0] drive_out;
  logic       drive_oe;

  int tests = 0, fails = 0, ref_cycles = 0;
  bit done = 1'b0;
  // Expected polarity from the strap: 1 means active-low
  logic [1:0] pol_exp = 2'b10;

  pwm_switch_driver dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .ref_clk(ref_clk),
    .ref_rst_n(ref_rst_n), .pol_strap(pol_strap), .fb_in(fb_in), .cfg_sel(cfg_sel),
    .drive_out(drive_out), .drive_oe(drive_oe)
  );

  always #(CLK_PERIOD/2) pclk = ~pclk;
  always #(REF_PERIOD/2) ref_clk = ~ref_clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit is_act(int ch);
    return drive_out[ch] ^ pol_exp[ch];
  endfunction

  task automatic ref_wait(int n);
    for (int i = 0; i < n; i++) @(negedge ref_clk);
  endtask

  task automatic bus_write(int off, logic [7:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; paddr = off[5:0]; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_read(int off, output logic [7:0] d);
    @(negedge pclk); psel = 1; pwrite = 0; paddr = off[5:0];
    @(negedge pclk); penable = 1; #1 d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  // Behavioural waveform model: lock on a rise of the active level, then compare each cycle
  task automatic check_pattern(int ch, int per, int hi, string req);
    bit prev, found = 0, bad = 0;
    int first_i = 0, first_a = 0, first_e = 0;
    @(negedge ref_clk); prev = is_act(ch);
    for (int k = 0; k < 1000 && !found; k++) begin
      @(negedge ref_clk);
      if (is_act(ch) && !prev) found = 1;
      prev = is_act(ch);
    end
    if (found) begin
      for (int i = 1; i < 3*(per+1); i++) begin
        bit e;
        @(negedge ref_clk);
        e = (i % (per+1)) < hi;
        if (is_act(ch) != e && !bad) begin bad = 1; first_i = i; first_a = is_act(ch); first_e = e; end
      end
    end
    check(found && !bad, req, found ? first_a : 0, found ? first_e : 1);
    if (bad) $display("  channel %0d mismatch at cycle %0d of the locked pattern", ch, first_i);
  endtask

  task automatic check_const(int ch, bit lvl, int n, string req);
    int wrong = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge ref_clk);
      if (is_act(ch) != lvl) wrong++;
    end
    check(wrong == 0, req, wrong, 0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge ref_clk);
      ref_cycles++;
      if (ref_cycles > WATCHDOG && !done) begin
        fails++; tests++;
        $display("FAIL watchdog: actual %0d expected below %0d", ref_cycles, WATCHDOG);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin : main
    logic [7:0] rd;
    int run;
    logic [7:0] vals [8] = '{8'd9, 8'd3, 8'd4, 8'd2, 8'd6, 8'd4, 8'd11, 8'd12};

    ref_wait(5);
    // R2, R8: reset state
    check(drive_out == pol_strap, "R2 inactive level in reset", drive_out, pol_strap);
    check(drive_oe == 1'b0, "R8 enable low in reset", drive_oe, 0);
    presetn = 1'b1;
    @(negedge ref_clk); ref_rst_n = 1'b1;
    #1 check(drive_oe == 1'b0, "R8 enable before first edge", drive_oe, 0);
    @(negedge ref_clk);
    check(drive_oe == 1'b1, "R8 enable one edge after release", drive_oe, 1);

    // R1: write and read back all slots
    for (int k = 0; k < 8; k++) bus_write(k, vals[k]);
    for (int k = 0; k < 8; k++) begin
      bus_read(k, rd);
      check(rd == vals[k], "R1 readback", rd, vals[k]);
    end
    bus_read(12, rd);
    check(rd == 8'd0, "R1 unmapped offset reads zero", rd, 0);

    // R9: setup cycle without penable must not write
    @(negedge pclk); psel = 1; pwrite = 1; paddr = 6'd0; pwdata = 8'hA5;
    @(negedge pclk); psel = 0; pwrite = 0;
    bus_read(0, rd);
    check(rd == 8'd9, "R9 no write without penable", rd, 9);

    // R4, R5, R7: setting 0 on both channels, R2 active-low on channel 1
    fb_in = 2'b11;
    ref_wait(300);
    check_pattern(0, 9, 3, "R4 R5 R7 ch0 setting 0");
    check_pattern(1, 6, 4, "R2 R5 ch1 active-low setting 0");

    // R6: switch ch0 select right after a pulse ends; old period must finish
    run = 0;
    for (int k = 0; k < 1000 && run == 0; k++) begin
      bit p;
      p = is_act(0);
      @(negedge ref_clk);
      if (p && !is_act(0)) run = 1;
    end
    cfg_sel[0] = 1'b1;
    run = 1;
    @(negedge ref_clk);
    while (!is_act(0) && run < 50) begin run++; @(negedge ref_clk); end
    check(run == 7, "R6 old period finishes after select change", run, 7);
    run = 0;
    while (is_act(0) && run < 50) begin run++; @(negedge ref_clk); end
    check(run == 2, "R6 first pulse uses new setting", run, 2);
    check_pattern(0, 4, 2, "R4 ch0 setting 1");

    // R5: high-time above period keeps ch1 active
    cfg_sel[1] = 1'b1;
    ref_wait(300);
    check_const(1, 1'b1, 40, "R5 high above period constant active");

    // R3: feedback low gates ch0, ch1 untouched (R1 independence)
    fb_in[0] = 1'b0;
    ref_wait(5);
    check_const(0, 1'b0, 40, "R3 feedback low holds inactive");
    check_const(1, 1'b1, 20, "R1 other channel unaffected");
    fb_in[0] = 1'b1;
    ref_wait(5);
    check_pattern(0, 4, 2, "R3 feedback high resumes");

    // R5, R7: high-time zero on ch0 setting 0
    cfg_sel[0] = 1'b0;
    bus_write(1, 8'd0);
    ref_wait(300);
    check_const(0, 1'b0, 40, "R5 R7 zero high-time constant inactive");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule